// File: doc/BRIEF.md
# Framed Serial Conversion-Result Transmitter

This block sends a 14-bit conversion result over a three-wire serial link. The wires are a serial clock, a data line and an active-low frame strobe. A start request marks the beginning of a conversion. The block latches the result word at that point and sends a 16-bit frame while the conversion is still running. The frame is two zero pad bits followed by the result, most significant bit first. The serial clock is made from the master clock at half its rate. The receiver samples data on the falling edges of the serial clock, and the data changes only on the rising edges.

Each line is open-drain. The block never drives a line high. It only asserts an enable that pulls the line low, and an external pull-up sets the high level. A mode input selects how the serial clock behaves between frames. In continuous mode it keeps toggling. In non-continuous mode it is released after each frame, so several transmitters can share one clock wire.

Top module: `serialResultTx`

## Requirements
- R1: A frame holds 16 bits, one read at each falling edge of the serial clock line. Bits 1 and 2 are zero. Bits 3 to 16 are resultIn[13] down to resultIn[0].
- R2: The data line changes only on master clock edges where the serial clock line rises, or where the frame starts or ends. It is therefore constant across every falling edge.
- R3: The strobe line goes low on the master edge that accepts a start. The serial clock does not fall on that edge, so the first falling edge carries the first pad zero.
- R4: Each frame has exactly 16 falling edges. The strobe is released on the rising edge after the 16th fall, so it stays low for 32 master cycles.
- R5: The serial clock line toggles on every master clock edge while a frame is active, which is half the master rate.
- R6: With contMode=0 and no frame active, the clock pull-low output is 0, so the line is released high.
- R7: With contMode=1, the serial clock toggles on every master edge even when no frame is active.
- R8: Each of sclkLow, sdataLow and strobeLow is a pull-low enable: 1 pulls the line low and 0 releases it. All three are 0 during reset.
- R9: A start request made while a frame is active is ignored. It neither restarts the frame, changes its data, nor queues a second frame.
- R10: With contMode=0, a start is accepted on the next master edge. With contMode=1, it is held until the first edge on which the clock rises, which is at most two edges after the request.
- R11: The data line is released whenever the strobe line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master conversion clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Conversion start request, one cycle |
| resultIn | input | 14 | Result word captured when a start is accepted |
| contMode | input | 1 | 1: serial clock runs continuously; 0: released between frames |
| sclkLow | output | 1 | Pull-low enable for the serial clock line |
| sdataLow | output | 1 | Pull-low enable for the serial data line |
| strobeLow | output | 1 | Pull-low enable for the frame strobe line |

## Verification
On every cycle, the assertions check the following. The data line changes only at rising clock edges or at the frame boundaries. The strobe never starts on a falling edge. The clock toggles on every edge while a frame runs, and also when idle in continuous mode. The clock stays released when idle in non-continuous mode. A frame ends only after 16 falls. The data is released whenever the strobe is. The first shifted bit after a load is a pad zero. Other behaviours can only be shown by the bench scenarios, which decode frames as a receiver would. These are the full bit content for several result patterns, the strobe width, and the start latency in each mode. They also cover a start request made during a frame, which must be ignored, and the released lines during reset.

// File: rtl/srtPkg.sv
package srtPkg;
  typedef struct packed {
    logic load;   // capture result and pad bits
    logic shift;  // advance to the next bit on a rising serial edge
    logic drive;  // frame active: data line may be pulled low
  } srtCmd_t;
endpackage

// File: rtl/srtCtrl.sv
module srtCtrl
  import srtPkg::*;
#(
  parameter int FRAME_BITS = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    contMode,
  output srtCmd_t cmd,
  output logic    sclkLowQ,
  output logic    activeQ
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS);

  logic             pendQ;
  logic [CNT_W-1:0] fallCnt;
  logic             running, accept, fallNow, riseNow, lastBit;

  always_comb begin
    running = contMode || activeQ;
    // in continuous mode wait until the next edge is a rise
    accept  = (startReq || pendQ) && !activeQ && (!contMode || sclkLowQ);
    fallNow = activeQ && !sclkLowQ;
    riseNow = activeQ && sclkLowQ;
    lastBit = (fallCnt == LAST);
    cmd.load  = accept;
    cmd.shift = riseNow && !lastBit;
    cmd.drive = activeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkLowQ <= 1'b0;
      activeQ  <= 1'b0;
      pendQ    <= 1'b0;
      fallCnt  <= '0;
    end else begin
      sclkLowQ <= running ? !sclkLowQ : 1'b0;
      if (accept) begin
        activeQ <= 1'b1;
        pendQ   <= 1'b0;
        fallCnt <= '0;
      end else begin
        if (riseNow && lastBit) activeQ <= 1'b0;
        if (startReq && !activeQ) pendQ <= 1'b1;
        if (fallNow) fallCnt <= fallCnt + 1'b1;
      end
    end
  end

  // R4: frame ends only after the full count of falling edges
  a_r4_end_after_count: assert property (@(posedge clk) disable iff (!rstN)
    $fell(activeQ) |-> fallCnt == LAST);
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    fallCnt <= LAST);
  // R5: half-rate toggling inside a frame
  a_r5_toggle_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ && $past(activeQ)) |-> !$stable(sclkLowQ));
  // R6: clock released while idle in non-continuous mode
  a_r6_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(activeQ) && !$past(contMode)) |-> !sclkLowQ);
  // R7: continuous mode keeps the clock running
  a_r7_cont_toggle: assert property (@(posedge clk) disable iff (!rstN)
    $past(contMode) |-> !$stable(sclkLowQ));
  // R10: non-continuous start taken on the next edge
  a_r10_noncont_start: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !activeQ && !contMode) |=> activeQ);
endmodule

// File: rtl/srtShift.sv
module srtShift
  import srtPkg::*;
#(
  parameter int RESULT_BITS = 14,
  parameter int FRAME_BITS  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  srtCmd_t                cmd,
  input  logic [RESULT_BITS-1:0] resultIn,
  output logic                   sdataLow
);
  localparam int PAD_BITS = FRAME_BITS - RESULT_BITS;

  logic [FRAME_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shreg <= '0;
    else if (cmd.load) shreg <= {{PAD_BITS{1'b0}}, resultIn};
    else if (cmd.shift) shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
  end

  assign sdataLow = cmd.drive && !shreg[FRAME_BITS-1];

  // R1: a freshly loaded frame begins with a pad zero
  a_r1_pad_first: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmd.load) |-> !shreg[FRAME_BITS-1]);
endmodule

// File: rtl/serialResultTx.sv
module serialResultTx
  import srtPkg::*;
#(
  parameter int RESULT_BITS = 14,
  parameter int FRAME_BITS  = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startReq,
  input  logic [RESULT_BITS-1:0] resultIn,
  input  logic                   contMode,
  output logic                   sclkLow,
  output logic                   sdataLow,
  output logic                   strobeLow
);
  srtCmd_t cmd;
  logic    sclkLowQ, activeQ;

  srtCtrl #(.FRAME_BITS(FRAME_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .contMode(contMode),
    .cmd(cmd), .sclkLowQ(sclkLowQ), .activeQ(activeQ)
  );

  srtShift #(.RESULT_BITS(RESULT_BITS), .FRAME_BITS(FRAME_BITS)) uShift (
    .clk(clk), .rstN(rstN), .cmd(cmd), .resultIn(resultIn), .sdataLow(sdataLow)
  );

  assign sclkLow   = sclkLowQ;
  assign strobeLow = activeQ;

  // R2: data moves only with a rising serial clock or a frame boundary
  a_r2_data_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdataLow) |-> ($fell(sclkLow) || !$stable(strobeLow)));
  // R3: the strobe never starts on a falling serial edge
  a_r3_strobe_no_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeLow) |-> !sclkLow);
  // R11: data released whenever the strobe is released
  a_r11_data_released: assert property (@(posedge clk) disable iff (!rstN)
    !strobeLow |-> !sdataLow);
endmodule

// File: tb/sim_serialResultTx.sv
`timescale 1ns/1ps
module sim_serialResultTx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [13:0] resultIn = '0;
  logic contMode = 1'b0;
  logic sclkLow, sdataLow, strobeLow;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serialResultTx u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .resultIn(resultIn),
    .contMode(contMode), .sclkLow(sclkLow), .sdataLow(sdataLow), .strobeLow(strobeLow)
  );

  // line levels with external pull-ups
  wire sclkLine = !sclkLow;
  wire sdatLine = !sdataLow;
  wire strbLine = !strobeLow;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // receiver model: start a frame and decode it from the lines
  task automatic runFrame(input logic [13:0] res, input bit cont, input bit poke,
                          output int word, output int falls, output int strobeCyc,
                          output int waitCyc, output bit stable);
    bit prevS, prevD;
    @(negedge clk);
    contMode = cont; resultIn = res; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitCyc = 1;
    while (strbLine && waitCyc < 4) begin
      @(negedge clk);
      waitCyc++;
    end
    word = 0; falls = 0; strobeCyc = 0; stable = 1;
    prevS = 1'b1; prevD = sdatLine;
    while (!strbLine && strobeCyc < 100) begin
      strobeCyc++;
      if (prevS && !sclkLine) begin
        falls++;
        word = (word << 1) | int'(sdatLine);
        if (sdatLine != prevD) stable = 0;
      end
      prevS = sclkLine; prevD = sdatLine;
      startReq = poke && (strobeCyc == 10);
      if (poke && strobeCyc == 10) resultIn = ~res;
      @(negedge clk);
    end
    startReq = 1'b0;
  endtask

  task automatic testReset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!sclkLow && !sdataLow && !strobeLow, "R8 reset releases lines",
            {sclkLow, sdataLow, strobeLow}, 0);
    end
    rstN = 1'b1;
    @(negedge clk);
    check(sclkLine && strbLine, "R6 idle clock high after reset", sclkLine, 1);
  endtask

  task automatic testFrame(input logic [13:0] res, input bit cont);
    int w, f, s, wc; bit st;
    runFrame(res, cont, 1'b0, w, f, s, wc, st);
    check(w == int'(res), "R1 frame bits (pads zero, MSB first)", w, int'(res));
    check(f == 16, "R4 falling edges per frame", f, 16);
    check(s == 32, "R5 strobe width at half rate", s, 32);
    check(st, "R2 data stable across falling edges", st, 1);
    if (cont) check(wc <= 2, "R10 continuous start latency", wc, 2);
    else check(wc == 1, "R3 R10 strobe on accepting edge", wc, 1);
    check(sdatLine, "R11 data released after frame", sdatLine, 1);
  endtask

  task automatic testIdle(input bit cont);
    int toggles = 0; bit prev; bit anyLow = 0;
    contMode = cont;
    @(negedge clk); @(negedge clk);
    prev = sclkLine;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (sclkLine != prev) toggles++;
      if (!sclkLine) anyLow = 1;
      prev = sclkLine;
    end
    if (cont) check(toggles == 8, "R7 continuous idle toggles", toggles, 8);
    else check(!anyLow && toggles == 0, "R6 non-continuous idle released", toggles, 0);
  endtask

  task automatic testIgnore();
    int w, f, s, wc; bit st; bit again = 0;
    runFrame(14'h1234, 1'b0, 1'b1, w, f, s, wc, st);
    check(w == 14'h1234, "R9 start during frame keeps data", w, 14'h1234);
    check(s == 32, "R9 start during frame no restart", s, 32);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!strbLine) again = 1;
    end
    check(!again, "R9 no queued frame", again, 0);
  endtask

  initial begin
    testReset();
    testFrame(14'h2AAA, 1'b0);
    testIdle(1'b0);
    testFrame(14'h3FFF, 1'b0);
    testFrame(14'h0000, 1'b0);
    testIdle(1'b1);
    testFrame(14'h1555, 1'b1);
    @(negedge clk);
    testFrame(14'h0F0F, 1'b1);
    testIgnore();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule